// File: doc/BRIEF.md
# Interframe Gap and Collision Retry Controller

This block paces the transmit side of an Ethernet MAC one frame attempt at a time. It holds off every transmit start until a programmable idle gap has passed since the previous attempt ended. It also counts the failed attempts of the current frame and decides after each collision whether the MAC should try again or drop the frame. The gap is counted in clock cycles. One gap unit is 40 ns at 100 Mb/s, and that unit is scaled by ten at 10 Mb/s. A 2-bit gap code removes whole units from the nominal gap.

The MAC pulses `tx_req` when it has a frame, or a retry of one, ready to send. A request that arrives while an attempt is running or while the gap is still counting is remembered, and it is granted once the gap is over. The block grants the request with a single-cycle `tx_start`. After that it waits for the MAC to report the outcome on `tx_collision` or `tx_success`. The block does not randomise backoff slots: the MAC delays its next `tx_req` by whatever backoff it chooses.

Failures are counted in groups of 16. Each completed group raises the excessive-collision count by one. In plain mode the first completed group aborts the frame. In extended mode the frame is aborted only when the fourth group completes, which is the 64th failure. The excessive-collision count is left in place after the frame ends, so the MAC can put it into the frame status. All control pins are plain levels or pulses. The block has no data path and no valid/ready stream.

Top module: `ifg_retry_ctrl`

## Requirements
- R1: Out of reset, `tx_start`, `tx_retry` and `tx_abort` are low and `exc_col_cnt` is 0. No gap is pending after reset, so a `tx_req` sampled at the first edge after reset produces `tx_start` high in the next cycle.
- R2: At 100 Mb/s (`speed_10m`=0) the gap is (24 − `gap_code`) × CYC_PER_UNIT cycles. When a request is already pending, `tx_start` goes high gap+1 clock edges after the edge that samples the end of the previous attempt.
- R3: At 10 Mb/s (`speed_10m`=1) the gap is (240 − 10 × `gap_code`) × CYC_PER_UNIT cycles, with the same timing as in R2.
- R4: `speed_10m` and `gap_code` are sampled at the edge where an attempt ends. Changing them while the gap is counting does not change that gap.
- R5: A `tx_req` pulse that arrives during the gap is held. It yields exactly one `tx_start`, and that `tx_start` comes at the normal gap timing.
- R6: `tx_success` during an attempt ends the frame without a retry or abort pulse, and it clears the failure count. When `tx_collision` and `tx_success` come in the same cycle, the collision wins.
- R7: A collision that does not complete the last allowed group pulses `tx_retry` for one cycle, one edge after it is sampled. The retry attempt must again wait out the full gap.
- R8: With `retry_ext_en`=0, the 16th failed attempt pulses `tx_abort` instead of `tx_retry`, and `exc_col_cnt` becomes 1.
- R9: With `retry_ext_en`=1, failures 16, 32 and 48 still pulse `tx_retry`, with `exc_col_cnt` at 1, 2 and 3. The 64th failure pulses `tx_abort` and sets `exc_col_cnt` to 4.
- R10: `exc_col_cnt` keeps its value after the frame ends by success or abort. It returns to 0 on the `tx_start` of the next new frame. For example, a success after 20 failures in extended mode leaves it at 1.
- R11: `tx_collision` and `tx_success` outside an attempt are ignored: no `tx_retry`, no `tx_abort`, and `exc_col_cnt` does not change.
- R12: `tx_start`, `tx_retry` and `tx_abort` are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Pulse: a frame or retry is ready to transmit |
| tx_collision | input | 1 | Pulse: the current attempt failed on a collision |
| tx_success | input | 1 | Pulse: the current attempt completed |
| speed_10m | input | 1 | 1 selects 10 Mb/s gap scaling, 0 selects 100 Mb/s |
| gap_code | input | 2 | Number of 40 ns units (×10 at 10 Mb/s) removed from the gap |
| retry_ext_en | input | 1 | 1 allows four groups of 16 attempts instead of one |
| tx_start | output | 1 | Pulse: permission to begin an attempt |
| tx_retry | output | 1 | Pulse: the frame will be retried |
| tx_abort | output | 1 | Pulse: the frame is dropped |
| exc_col_cnt | output | $clog2(MAX_GROUPS+1) | Completed groups of 16 failures for the current or last frame |

## Verification
The hardest case to reach is the extended-mode abort. It needs 64 collisions on a single frame, and each retry has to sit through a full gap before it can start. A directed task drives this sequence to the end. It checks the retry pulses and the excessive count at each group boundary, then the abort on the 64th collision. A second task ends a frame with success after 20 failures. This shows that the excessive count outlives the frame and is cleared only by the next fresh start. The bench shortens the gap unit through the parameter so that these long sequences stay affordable.

// File: rtl/ifg_retry_pkg.sv
package ifg_retry_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } tx_state_e;

  // gap length in 40 ns units (scaled for the slow line rate)
  function automatic int unsigned gap_units(input logic slow,
                                            input logic [1:0] code,
                                            input int unsigned fast_units,
                                            input int unsigned slow_scale);
    int unsigned base;
    base = fast_units - int'(code);
    return slow ? base * slow_scale : base;
  endfunction

endpackage

// File: rtl/ifg_gap_timer.sv
module ifg_gap_timer #(
  parameter int unsigned CYC_PER_UNIT = 10,
  parameter int unsigned MAX_UNITS    = 240,
  localparam int unsigned UW = $clog2(MAX_UNITS + 1),
  localparam int unsigned CW = $clog2(MAX_UNITS * CYC_PER_UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [UW-1:0] load_units,
  output logic          expired
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  assign load_val = CW'(load_units) * CW'(CYC_PER_UNIT);
  assign expired  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (!expired)   cnt <= cnt - CW'(1);
  end

  a_r2_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt == $past(cnt) - CW'(1)));

  a_r4_load_captured: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/ifg_attempt_ctr.sv
module ifg_attempt_ctr #(
  parameter int unsigned GROUP_LEN  = 16,
  parameter int unsigned MAX_GROUPS = 4,
  localparam int unsigned FW = $clog2(GROUP_LEN),
  localparam int unsigned XW = $clog2(MAX_GROUPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          collide,
  input  logic          clear_fails,
  input  logic          clear_status,
  input  logic          ext_en,
  output logic          give_up,
  output logic [XW-1:0] exc_cnt
);

  logic [FW-1:0] fail_cnt;
  logic          group_end;
  logic [XW-1:0] exc_next;
  logic [XW-1:0] limit;

  assign group_end = (fail_cnt == FW'(GROUP_LEN - 1));
  assign exc_next  = exc_cnt + XW'(1);
  assign limit     = ext_en ? XW'(MAX_GROUPS) : XW'(1);
  assign give_up   = collide && group_end && (exc_next >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_cnt <= '0;
    end else if (collide) begin
      fail_cnt <= group_end ? '0 : fail_cnt + FW'(1);
    end else if (clear_fails) begin
      fail_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     exc_cnt <= '0;
    else if (clear_status)          exc_cnt <= '0;
    else if (collide && group_end)  exc_cnt <= exc_next;
  end

  a_r9_exc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    exc_cnt <= XW'(MAX_GROUPS));

  a_r8_abort_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> (fail_cnt == '0));

  a_r6_success_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_fails && !collide) |=> (fail_cnt == '0));

endmodule

// File: rtl/ifg_retry_ctrl.sv
module ifg_retry_ctrl
  import ifg_retry_pkg::*;
#(
  parameter int unsigned CYC_PER_UNIT = 10,
  parameter int unsigned FAST_UNITS   = 24,
  parameter int unsigned SLOW_SCALE   = 10,
  parameter int unsigned GROUP_LEN    = 16,
  parameter int unsigned MAX_GROUPS   = 4,
  localparam int unsigned MAX_UNITS = FAST_UNITS * SLOW_SCALE,
  localparam int unsigned UW = $clog2(MAX_UNITS + 1),
  localparam int unsigned XW = $clog2(MAX_GROUPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req,
  input  logic          tx_collision,
  input  logic          tx_success,
  input  logic          speed_10m,
  input  logic [1:0]    gap_code,
  input  logic          retry_ext_en,
  output logic          tx_start,
  output logic          tx_retry,
  output logic          tx_abort,
  output logic [XW-1:0] exc_col_cnt
);

  tx_state_e     state;
  logic          pend;
  logic          frame_open;
  logic          gap_done;
  logic          fire;
  logic          col_evt;
  logic          ok_evt;
  logic          give_up;
  logic [UW-1:0] units;

  assign col_evt = (state == ST_BUSY) && tx_collision;
  assign ok_evt  = (state == ST_BUSY) && tx_success && !tx_collision;
  assign fire    = (state == ST_IDLE) && gap_done && (pend || tx_req);
  assign units   = UW'(gap_units(speed_10m, gap_code, FAST_UNITS, SLOW_SCALE));

  ifg_gap_timer #(
    .CYC_PER_UNIT (CYC_PER_UNIT),
    .MAX_UNITS    (MAX_UNITS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (col_evt || ok_evt),
    .load_units (units),
    .expired    (gap_done)
  );

  ifg_attempt_ctr #(
    .GROUP_LEN  (GROUP_LEN),
    .MAX_GROUPS (MAX_GROUPS)
  ) u_attempts (
    .clk          (clk),
    .rst_n        (rst_n),
    .collide      (col_evt),
    .clear_fails  (ok_evt),
    .clear_status (fire && !frame_open),
    .ext_en       (retry_ext_en),
    .give_up      (give_up),
    .exc_cnt      (exc_col_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend       <= 1'b0;
      frame_open <= 1'b0;
      tx_start   <= 1'b0;
      tx_retry   <= 1'b0;
      tx_abort   <= 1'b0;
    end else begin
      tx_start <= fire;
      tx_retry <= col_evt && !give_up;
      tx_abort <= give_up;
      if (fire)        pend <= 1'b0;
      else if (tx_req) pend <= 1'b1;
      if (fire)                  frame_open <= 1'b1;
      else if (ok_evt || give_up) frame_open <= 1'b0;
      if (fire)                   state <= ST_BUSY;
      else if (col_evt || ok_evt) state <= ST_IDLE;
    end
  end

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_start, tx_retry, tx_abort}));

  a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (!tx_retry && !tx_abort));

  a_r6_success_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ok_evt |=> (!tx_retry && !tx_abort && !tx_start));

  a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(state) == ST_IDLE) && (state == ST_BUSY));

endmodule

// File: tb/ifg_retry_ctrl_test.sv
module ifg_retry_ctrl_test;

  localparam int CPU = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0;
  logic       tx_collision = 1'b0;
  logic       tx_success = 1'b0;
  logic       speed_10m = 1'b0;
  logic [1:0] gap_code = 2'd0;
  logic       retry_ext_en = 1'b0;
  logic       tx_start, tx_retry, tx_abort;
  logic [2:0] exc_col_cnt;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ifg_retry_ctrl #(.CYC_PER_UNIT(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_collision(tx_collision),
    .tx_success(tx_success), .speed_10m(speed_10m), .gap_code(gap_code),
    .retry_ext_en(retry_ext_en), .tx_start(tx_start), .tx_retry(tx_retry),
    .tx_abort(tx_abort), .exc_col_cnt(exc_col_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fast_gap(input int code);
    return (24 - code) * CPU;
  endfunction

  function automatic int slow_gap(input int code);
    return (240 - 10 * code) * CPU;
  endfunction

  // called at a negedge; ends at a negedge
  task automatic end_event(input bit c, input bit o, output bit r, output bit a);
    tx_collision = c;
    tx_success   = o;
    @(posedge clk); #1;
    r = tx_retry;
    a = tx_abort;
    @(negedge clk);
    tx_collision = 1'b0;
    tx_success   = 1'b0;
  endtask

  // called at a negedge; request pulsed in cycle req_at (0 = none)
  task automatic watch(input int req_at, input int lim, output int first, output int cnt);
    first = 0;
    cnt   = 0;
    for (int n = 1; n <= lim; n++) begin
      tx_req = (n == req_at);
      @(posedge clk); #1;
      if (tx_start) begin
        cnt++;
        if (first == 0) first = n;
      end
      @(negedge clk);
    end
    tx_req = 1'b0;
  endtask

  task automatic begin_attempt(input int gap);
    int f, c;
    watch(1, gap + 3, f, c);
    if (f == 0) check("start_missing", 0, 1);
  endtask

  task automatic t_reset;
    check("R1 start", int'(tx_start), 0);
    check("R1 retry", int'(tx_retry), 0);
    check("R1 abort", int'(tx_abort), 0);
    check("R1 exc", int'(exc_col_cnt), 0);
    @(negedge clk);
    tx_req = 1'b1;
    @(posedge clk); #1;
    check("R1 immediate start", int'(tx_start), 1);
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic t_gap_fast;
    bit r, a;
    int f, c;
    for (int code = 0; code < 4; code += 3) begin
      speed_10m = 1'b0;
      gap_code  = 2'(code);
      tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
      end_event(0, 1, r, a);
      check("R6 success no retry", int'(r), 0);
      check("R6 success no abort", int'(a), 0);
      watch(0, fast_gap(code) + 5, f, c);
      check("R2 fast gap", f, fast_gap(code) + 1);
    end
  endtask

  task automatic t_gap_slow;
    bit r, a;
    int f, c;
    for (int code = 0; code < 4; code += 2) begin
      speed_10m = 1'b1;
      gap_code  = 2'(code);
      tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
      end_event(0, 1, r, a);
      watch(0, slow_gap(code) + 5, f, c);
      check("R3 slow gap", f, slow_gap(code) + 1);
    end
    speed_10m = 1'b0;
    gap_code  = 2'd0;
  endtask

  task automatic t_sample;
    bit r, a;
    int f, c;
    tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
    end_event(0, 1, r, a);
    speed_10m = 1'b1;
    gap_code  = 2'd3;
    watch(0, fast_gap(0) + 5, f, c);
    check("R4 gap sampled at end", f, fast_gap(0) + 1);
    speed_10m = 1'b0;
    gap_code  = 2'd0;
  endtask

  task automatic t_hold;
    bit r, a;
    int f, c;
    end_event(0, 1, r, a);
    watch(10, fast_gap(0) + 40, f, c);
    check("R5 held start time", f, fast_gap(0) + 1);
    check("R5 single start", c, 1);
  endtask

  task automatic t_plain_abort;
    bit r, a;
    int f, c;
    retry_ext_en = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      end_event(1, 0, r, a);
      if (i < 16) begin
        check("R7 retry", int'(r), 1);
        check("R7 no abort", int'(a), 0);
        watch(1, fast_gap(0) + 3, f, c);
        if (i == 1) check("R7 retry waits gap", f, fast_gap(0) + 1);
      end else begin
        check("R8 abort at 16", int'(a), 1);
        check("R8 no retry", int'(r), 0);
        check("R8 exc count", int'(exc_col_cnt), 1);
      end
    end
    repeat (fast_gap(0) + 2) @(negedge clk);
    end_event(1, 0, r, a);
    check("R11 idle collision retry", int'(r), 0);
    check("R11 idle collision abort", int'(a), 0);
    end_event(0, 1, r, a);
    check("R11 idle success pulse", int'(r | a), 0);
    check("R11 exc unchanged", int'(exc_col_cnt), 1);
    check("R10 exc held after abort", int'(exc_col_cnt), 1);
    begin_attempt(0);
    check("R10 exc cleared on new frame", int'(exc_col_cnt), 0);
  endtask

  task automatic t_clear;
    bit r, a;
    retry_ext_en = 1'b0;
    end_event(1, 1, r, a);
    check("R6 collision wins", int'(r), 1);
    begin_attempt(fast_gap(0));
    for (int i = 2; i <= 10; i++) begin
      end_event(1, 0, r, a);
      begin_attempt(fast_gap(0));
    end
    end_event(0, 1, r, a);
    begin_attempt(fast_gap(0));
    for (int i = 1; i <= 16; i++) begin
      end_event(1, 0, r, a);
      if (i == 15) check("R6 count cleared by success", int'(r), 1);
      if (i == 16) check("R8 abort after clear", int'(a), 1);
      if (i < 16) begin_attempt(fast_gap(0));
    end
    repeat (fast_gap(0) + 2) @(negedge clk);
    begin_attempt(0);
  endtask

  task automatic t_ext;
    bit r, a;
    retry_ext_en = 1'b1;
    for (int i = 1; i <= 64; i++) begin
      end_event(1, 0, r, a);
      if (i == 16 || i == 32 || i == 48) begin
        check("R9 group retry", int'(r), 1);
        check("R9 group exc", int'(exc_col_cnt), i / 16);
      end
      if (i == 64) begin
        check("R9 abort at 64", int'(a), 1);
        check("R9 no retry at 64", int'(r), 0);
        check("R9 exc at 64", int'(exc_col_cnt), 4);
      end else begin
        begin_attempt(fast_gap(0));
      end
    end
    repeat (fast_gap(0) + 2) @(negedge clk);
    begin_attempt(0);
  endtask

  task automatic t_ext_success;
    bit r, a;
    retry_ext_en = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      end_event(1, 0, r, a);
      begin_attempt(fast_gap(0));
    end
    end_event(0, 1, r, a);
    check("R10 no abort on success", int'(a), 0);
    check("R10 exc after success", int'(exc_col_cnt), 1);
    begin_attempt(fast_gap(0));
    check("R10 exc cleared", int'(exc_col_cnt), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_gap_fast();
    t_gap_slow();
    t_sample();
    t_hold();
    t_plain_abort();
    t_clear();
    t_ext();
    t_ext_success();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule